// File: doc/BRIEF.md
# SCSI Controller Interrupt and Status Unit

This block holds the interrupt cause register, the status register, the sequence-step register and the FIFO flags register of a SCSI protocol controller, and drives the interrupt request line. Sequencer events and host commands post cause bits: function complete, bus service, disconnect and bus reset. While any cause is pending, the block sets an interrupt-pending status bit and asserts the request line.

The host reads the registers through a small byte-wide register port. A read of the interrupt register is destructive. It returns the pending causes, then clears them. The same read clears the terminal-count status bit and the sequence step, so the request line drops. A configuration byte holds a bit that suppresses reporting of bus resets. The sequencer that runs commands sits outside this block. It loads the bus phase, the sequence step, the flags and terminal-count events through dedicated inputs.

Register addresses: 0 status, 1 interrupt, 2 sequence step, 3 FIFO flags, 4 configuration, 5 command.

Top module: `scsi_isr_unit`

## Requirements
- R1: After reset, status, interrupt, sequence step and flags read 0, the command register reads 0, `irq_o` is low and the configuration register (address 4) reads 0x07.
- R2: Interrupt register bit 3 (function complete), bit 4 (bus service) and bit 5 (disconnect) are set by `ev_fc_i`, `ev_bs_i` and `ev_dc_i`. `irq_o` and status bit 7 are high exactly while any interrupt bit is set.
- R3: A read of address 1 returns the pending causes. On that clock edge it clears the interrupt register, status bit 4 (terminal count) and the sequence step, so `irq_o` is low afterwards.
- R4: A cause posted in the same cycle as an interrupt-register read is not lost. It stays pending after the read, and the read returns only the causes pending before that cycle.
- R5: Writing command 0x03 (bus reset, bit 7 ignored) sets interrupt bit 7 only when configuration bit 6 is clear. When bit 6 is set, the command posts nothing.
- R6: While the stored command byte is exactly 0x10 (non-DMA transfer), each `fifo_wr_i` pulse sets interrupt bits 3 and 4. With the DMA form 0x90 stored, FIFO writes post nothing.
- R7: Writing command 0x12 (message accepted) sets interrupt bit 5 and clears the sequence step and the flags register.
- R8: Writing command 0x44 (enable selection) or 0x45 (disable selection) clears the interrupt register.
- R9: Status bits 2:0 show the bus phase loaded by `phase_we_i`. Reads of status, sequence step, flags and configuration have no side effect.
- R10: Host writes to addresses 0 to 3 change nothing. The configuration register is written at address 4 and reads back the value written.
- R11: `tc_set_i` sets status bit 4. The bit holds until an interrupt-register read clears it, and a `tc_set_i` in the read cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_rd_i | input | 1 | Host read strobe (side effects at the clock edge) |
| reg_wr_i | input | 1 | Host write strobe |
| reg_addr_i | input | ADDR_W | Host register address |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Read data for the addressed register, value before any side effect |
| fifo_wr_i | input | 1 | Host byte written into the data FIFO |
| ev_fc_i | input | 1 | Sequencer event: function complete |
| ev_bs_i | input | 1 | Sequencer event: bus service |
| ev_dc_i | input | 1 | Sequencer event: disconnect |
| tc_set_i | input | 1 | Transfer counter reached terminal count |
| phase_we_i | input | 1 | Load bus phase code |
| phase_i | input | PHASE_W | Bus phase code |
| seq_we_i | input | 1 | Load sequence step |
| seq_i | input | SEQ_W | Sequence step value |
| flags_we_i | input | 1 | Load FIFO flags register |
| flags_i | input | 8 | FIFO flags value |
| irq_o | output | 1 | Interrupt request, high while any cause pends |

## Verification
Assertions check on every cycle that a clearing read with no concurrent posting leaves the cause register empty, and that every posted cause lands. They also check that causes and terminal count stay stable when nothing touches them, that the sequence step is zero after a clearing read, and that a masked bus-reset command posts nothing. Only the directed scenarios can show the host-visible effects: the value a destructive read returns, the configuration reset value, the command decode for each code, the DMA form leaving FIFO writes silent, and writes to read-only addresses being ignored.

// File: rtl/scsi_isr_pkg.sv
package scsi_isr_pkg;
  localparam int REG_W = 8;

  // interrupt cause bit positions
  localparam int CAUSE_FC  = 3;
  localparam int CAUSE_BS  = 4;
  localparam int CAUSE_DC  = 5;
  localparam int CAUSE_RST = 7;

  // status bit positions (phase occupies the low bits)
  localparam int STAT_TC  = 4;
  localparam int STAT_INT = 7;

  typedef enum logic [2:0] {
    A_STAT  = 3'd0,
    A_INTR  = 3'd1,
    A_SEQ   = 3'd2,
    A_FLAGS = 3'd3,
    A_CFG   = 3'd4,
    A_CMD   = 3'd5
  } reg_addr_e;

  localparam int CMD_DMA_BIT = 7;
  typedef enum logic [6:0] {
    OP_NOP     = 7'h00,
    OP_BUS_RST = 7'h03,
    OP_XFER    = 7'h10,
    OP_MSG_ACC = 7'h12,
    OP_SEL_EN  = 7'h44,
    OP_SEL_DIS = 7'h45
  } cmd_op_e;
endpackage

// File: rtl/isr_cause_reg.sv
module isr_cause_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] cause_o,
  output logic         pend_o
);
  logic [W-1:0] cause_q;

  // posting wins over clearing so no cause is lost
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cause_q[i] <= 1'b0;
      else if (set_i[i]) cause_q[i] <= 1'b1;
      else if (clr_i)    cause_q[i] <= 1'b0;
    end
  end

  assign cause_o = cause_q;
  assign pend_o  = |cause_q;

  assert_clr_empties_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> cause_q == '0);
  assert_set_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((cause_q & $past(set_i)) == $past(set_i)));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_i == '0) |=> $stable(cause_q));
endmodule

// File: rtl/isr_status_regs.sv
module isr_status_regs #(
  parameter int PHASE_W = 3,
  parameter int SEQ_W   = 3,
  parameter int FLAG_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_we_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               tc_set_i,
  input  logic               tc_clr_i,
  input  logic               seq_we_i,
  input  logic [SEQ_W-1:0]   seq_i,
  input  logic               seq_clr_i,
  input  logic               flags_we_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic               flags_clr_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               tc_o,
  output logic [SEQ_W-1:0]   seq_o,
  output logic [FLAG_W-1:0]  flags_o
);
  logic [PHASE_W-1:0] phase_q;
  logic               tc_q;
  logic [SEQ_W-1:0]   seq_q;
  logic [FLAG_W-1:0]  flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         phase_q <= '0;
    else if (phase_we_i) phase_q <= phase_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tc_q <= 1'b0;
    else if (tc_set_i) tc_q <= 1'b1;
    else if (tc_clr_i) tc_q <= 1'b0;
  end

  // sequencer loads win over host-side clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seq_q <= '0;
    else if (seq_we_i)  seq_q <= seq_i;
    else if (seq_clr_i) seq_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flags_q <= '0;
    else if (flags_we_i)  flags_q <= flags_i;
    else if (flags_clr_i) flags_q <= '0;
  end

  assign phase_o = phase_q;
  assign tc_o    = tc_q;
  assign seq_o   = seq_q;
  assign flags_o = flags_q;

  assert_tc_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_set_i && !tc_clr_i) |=> $stable(tc_o));
  assert_seq_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_clr_i && !seq_we_i) |=> seq_o == '0);
endmodule

// File: rtl/isr_cmd_decode.sv
module isr_cmd_decode
  import scsi_isr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_we_i,
  input  logic [W-1:0] cmd_i,
  input  logic         rpt_dis_i,
  input  logic         fifo_wr_i,
  output logic [W-1:0] cmd_o,
  output logic [W-1:0] post_o,
  output logic         intr_clr_o,
  output logic         seq_flags_clr_o
);
  localparam logic [W-1:0] XFER_PIO = W'(OP_XFER);

  logic [W-1:0] cmd_q;
  logic [6:0]   op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_q <= '0;
    else if (cmd_we_i) cmd_q <= cmd_i;
  end

  assign op = cmd_i[6:0];

  always_comb begin
    post_o          = '0;
    intr_clr_o      = 1'b0;
    seq_flags_clr_o = 1'b0;
    if (cmd_we_i) begin
      case (op)
        OP_BUS_RST: post_o[CAUSE_RST] = !rpt_dis_i;
        OP_MSG_ACC: begin
          post_o[CAUSE_DC] = 1'b1;
          seq_flags_clr_o  = 1'b1;
        end
        OP_SEL_EN, OP_SEL_DIS: intr_clr_o = 1'b1;
        default: ;
      endcase
    end
    // programmed-I/O transfer: every host FIFO byte raises an interrupt
    if (fifo_wr_i && cmd_q == XFER_PIO) begin
      post_o[CAUSE_FC] = 1'b1;
      post_o[CAUSE_BS] = 1'b1;
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/scsi_isr_unit.sv
module scsi_isr_unit
  import scsi_isr_pkg::*;
#(
  parameter int          ADDR_W      = 3,
  parameter int          PHASE_W     = 3,
  parameter int          SEQ_W       = 3,
  parameter logic [7:0]  CFG_RST_VAL = 8'h07,
  parameter int          RPT_DIS_BIT = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_rd_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic               fifo_wr_i,
  input  logic               ev_fc_i,
  input  logic               ev_bs_i,
  input  logic               ev_dc_i,
  input  logic               tc_set_i,
  input  logic               phase_we_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               seq_we_i,
  input  logic [SEQ_W-1:0]   seq_i,
  input  logic               flags_we_i,
  input  logic [7:0]         flags_i,
  output logic               irq_o
);
  localparam int W = REG_W;

  logic          sel_intr, sel_cfg, sel_cmd;
  logic          intr_rd;
  logic [W-1:0]  cfg_q;
  logic [W-1:0]  cmd_q, post, cause_set, cause;
  logic          cmd_intr_clr, seq_flags_clr, pend;
  logic [PHASE_W-1:0] phase;
  logic          tc;
  logic [SEQ_W-1:0] seq;
  logic [W-1:0]  flags;
  logic [W-1:0]  stat;

  assign sel_intr = reg_addr_i == ADDR_W'(A_INTR);
  assign sel_cfg  = reg_addr_i == ADDR_W'(A_CFG);
  assign sel_cmd  = reg_addr_i == ADDR_W'(A_CMD);
  assign intr_rd  = reg_rd_i && sel_intr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cfg_q <= CFG_RST_VAL;
    else if (reg_wr_i && sel_cfg) cfg_q <= reg_wdata_i;
  end

  isr_cmd_decode #(.W(W)) u_dec (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cmd_we_i        (reg_wr_i && sel_cmd),
    .cmd_i           (reg_wdata_i),
    .rpt_dis_i       (cfg_q[RPT_DIS_BIT]),
    .fifo_wr_i       (fifo_wr_i),
    .cmd_o           (cmd_q),
    .post_o          (post),
    .intr_clr_o      (cmd_intr_clr),
    .seq_flags_clr_o (seq_flags_clr)
  );

  always_comb begin
    cause_set           = post;
    cause_set[CAUSE_FC] = post[CAUSE_FC] | ev_fc_i;
    cause_set[CAUSE_BS] = post[CAUSE_BS] | ev_bs_i;
    cause_set[CAUSE_DC] = post[CAUSE_DC] | ev_dc_i;
  end

  isr_cause_reg #(.W(W)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cause_set),
    .clr_i   (intr_rd || cmd_intr_clr),
    .cause_o (cause),
    .pend_o  (pend)
  );

  isr_status_regs #(.PHASE_W(PHASE_W), .SEQ_W(SEQ_W), .FLAG_W(W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_we_i  (phase_we_i),
    .phase_i     (phase_i),
    .tc_set_i    (tc_set_i),
    .tc_clr_i    (intr_rd),
    .seq_we_i    (seq_we_i),
    .seq_i       (seq_i),
    .seq_clr_i   (intr_rd || seq_flags_clr),
    .flags_we_i  (flags_we_i),
    .flags_i     (flags_i),
    .flags_clr_i (seq_flags_clr),
    .phase_o     (phase),
    .tc_o        (tc),
    .seq_o       (seq),
    .flags_o     (flags)
  );

  always_comb begin
    stat                = '0;
    stat[PHASE_W-1:0]   = phase;
    stat[STAT_TC]       = tc;
    stat[STAT_INT]      = pend;
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_W'(A_STAT):  reg_rdata_o = stat;
      ADDR_W'(A_INTR):  reg_rdata_o = cause;
      ADDR_W'(A_SEQ):   reg_rdata_o = W'(seq);
      ADDR_W'(A_FLAGS): reg_rdata_o = flags;
      ADDR_W'(A_CFG):   reg_rdata_o = cfg_q;
      ADDR_W'(A_CMD):   reg_rdata_o = cmd_q;
      default:          reg_rdata_o = '0;
    endcase
  end

  assign irq_o = pend;

  assert_rst_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && sel_cmd && reg_wdata_i[6:0] == OP_BUS_RST && cfg_q[RPT_DIS_BIT]
     && !cause[CAUSE_RST]) |=> !cause[CAUSE_RST]);
  assert_read_drops_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_rd && !ev_fc_i && !ev_bs_i && !ev_dc_i && !fifo_wr_i) |=> !irq_o);
endmodule

// File: tb/scsi_isr_unit_tb.sv
module scsi_isr_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_rd = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       fifo_wr = 0, ev_fc = 0, ev_bs = 0, ev_dc = 0, tc_set = 0;
  logic       phase_we = 0, seq_we = 0, flags_we = 0;
  logic [2:0] phase = 0, seq = 0;
  logic [7:0] flags = 0;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_isr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .fifo_wr_i(fifo_wr), .ev_fc_i(ev_fc), .ev_bs_i(ev_bs), .ev_dc_i(ev_dc),
    .tc_set_i(tc_set), .phase_we_i(phase_we), .phase_i(phase),
    .seq_we_i(seq_we), .seq_i(seq), .flags_we_i(flags_we), .flags_i(flags),
    .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a; #1;
    d = reg_rdata;
    tick();
    reg_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(0, d); chk("R1 status", d, 8'h00);
    rd(2, d); chk("R1 seq", d, 8'h00);
    rd(3, d); chk("R1 flags", d, 8'h00);
    rd(5, d); chk("R1 cmd", d, 8'h00);
    rd(4, d); chk("R1 cfg", d, 8'h07);
    rd(1, d); chk("R1 intr", d, 8'h00);
  endtask

  task automatic t_event();
    logic [7:0] d;
    ev_fc = 1; tick(); ev_fc = 0;
    chk("R2 irq high", {7'b0, irq}, 8'h01);
    rd(0, d); chk("R2 status int", d, 8'h80);
    rd(1, d); chk("R2 intr fc", d, 8'h08);
    chk("R3 irq low", {7'b0, irq}, 8'h00);
    rd(0, d); chk("R3 status after", d, 8'h00);
  endtask

  task automatic t_read_clear();
    logic [7:0] d;
    tc_set = 1; seq_we = 1; seq = 3'd5; ev_bs = 1; tick();
    tc_set = 0; seq_we = 0; ev_bs = 0;
    rd(0, d); chk("R11 status tc", d, 8'h90);
    rd(2, d); chk("R9 seq", d, 8'h05);
    rd(1, d); chk("R3 intr bs", d, 8'h10);
    rd(0, d); chk("R3 tc cleared", d, 8'h00);
    rd(2, d); chk("R3 seq cleared", d, 8'h00);
    // terminal count set in the read cycle survives
    reg_rd = 1; reg_addr = 1; tc_set = 1; tick(); reg_rd = 0; tc_set = 0;
    rd(0, d); chk("R11 tc wins", d, 8'h10);
    rd(1, d);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    reg_rd = 1; reg_addr = 1; ev_dc = 1; #1; d = reg_rdata;
    tick(); reg_rd = 0; ev_dc = 0;
    chk("R4 read value", d, 8'h00);
    chk("R4 irq kept", {7'b0, irq}, 8'h01);
    rd(1, d); chk("R4 dc kept", d, 8'h20);
  endtask

  task automatic t_bus_reset();
    logic [7:0] d;
    wr(5, 8'h03);
    chk("R5 reported irq", {7'b0, irq}, 8'h01);
    rd(1, d); chk("R5 rst cause", d, 8'h80);
    wr(4, 8'h47);
    wr(5, 8'h83);
    chk("R5 masked irq", {7'b0, irq}, 8'h00);
    rd(1, d); chk("R5 masked intr", d, 8'h00);
    wr(4, 8'h07);
  endtask

  task automatic t_xfer();
    logic [7:0] d;
    wr(5, 8'h10);
    fifo_wr = 1; tick(); fifo_wr = 0;
    rd(1, d); chk("R6 pio byte", d, 8'h18);
    wr(5, 8'h90);
    fifo_wr = 1; tick(); fifo_wr = 0;
    chk("R6 dma irq", {7'b0, irq}, 8'h00);
    rd(1, d); chk("R6 dma intr", d, 8'h00);
    wr(5, 8'h00);
  endtask

  task automatic t_msg_acc();
    logic [7:0] d;
    seq_we = 1; seq = 3'd3; flags_we = 1; flags = 8'h0A; tick();
    seq_we = 0; flags_we = 0;
    rd(3, d); chk("R9 flags load", d, 8'h0A);
    wr(5, 8'h12);
    rd(2, d); chk("R7 seq cleared", d, 8'h00);
    rd(3, d); chk("R7 flags cleared", d, 8'h00);
    rd(1, d); chk("R7 dc cause", d, 8'h20);
  endtask

  task automatic t_sel();
    logic [7:0] d;
    ev_fc = 1; ev_bs = 1; tick(); ev_fc = 0; ev_bs = 0;
    wr(5, 8'h44);
    chk("R8 enable clears irq", {7'b0, irq}, 8'h00);
    ev_dc = 1; tick(); ev_dc = 0;
    wr(5, 8'h45);
    rd(1, d); chk("R8 disable clears", d, 8'h00);
    wr(5, 8'h00);
  endtask

  task automatic t_status_ro();
    logic [7:0] d;
    phase_we = 1; phase = 3'd3; tc_set = 1; tick(); phase_we = 0; tc_set = 0;
    rd(0, d); chk("R9 status 1st", d, 8'h13);
    rd(0, d); chk("R9 status 2nd", d, 8'h13);
    rd(4, d); chk("R9 cfg read", d, 8'h07);
  endtask

  task automatic t_ignored_writes();
    logic [7:0] d;
    seq_we = 1; seq = 3'd6; flags_we = 1; flags = 8'h21; tick();
    seq_we = 0; flags_we = 0;
    for (int a = 0; a < 4; a++) wr(3'(a), 8'hFF);
    rd(0, d); chk("R10 status kept", d, 8'h13);
    chk("R10 irq kept low", {7'b0, irq}, 8'h00);
    rd(2, d); chk("R10 seq kept", d, 8'h06);
    rd(3, d); chk("R10 flags kept", d, 8'h21);
    wr(4, 8'h5A);
    rd(4, d); chk("R10 cfg readback", d, 8'h5A);
    wr(4, 8'h07);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_event();
    t_read_clear();
    t_same_cycle();
    t_bus_reset();
    t_xfer();
    t_msg_acc();
    t_sel();
    t_status_ro();
    t_ignored_writes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule